// File: doc/BRIEF.md
# Programmable Clock Divider with Source Selector

This block produces a selectable square wave from one fast clock. Every stage runs in that clock's domain and moves forward on enable pulses, so no derived clock is ever created. A phase bit flips on every enabled cycle and forms the full-rate source. A half-rate bit flips on every second cycle. Once every four cycles, a tick steps an 8-bit down-counter. The counter runs from a reload value down to zero. When it reaches zero it emits a one-cycle terminal pulse and takes its next count from a shadow register.

The terminal pulse flips a toggle stage. This rebuilds a square wave with equal high and low times from the narrow pulse. A registered four-way selector then chooses what drives the output: the full-rate phase bit, the half-rate bit, the programmable toggle, or a constant low.

A host writes a new reload value and a new source code through one write strobe. A source change is applied only while the output is low. A ready flag reports when the applied source matches the last code written.

Top module: `progclk_divider`

## Requirements
- R1: While `rst` is high, `clk_out` and `ready` are 0, and the dividers and the counter are cleared. After reset the applied source is code 3 (constant low), and `ready` is 1 from the first cycle after reset is released.
- R2: Source code 0 (full rate) makes `clk_out` high for 1 cycle and low for 1 cycle, repeating.
- R3: Source code 1 (half rate) makes `clk_out` high for 2 cycles and low for 2 cycles, repeating.
- R4: Source code 2 (programmable) makes `clk_out` high for 4×(P+1) cycles and low for 4×(P+1) cycles, where P is the reload value (0 to 255). P = 0 gives the minimum of 4.
- R5: A new reload value takes effect only at the counter's next reload. While the change settles, every half-period of the programmable output has either its full old length or its full new length, and later half-periods all have the new length.
- R6: Source code 3 holds `clk_out` at 0.
- R7: A change of the applied source happens only in a cycle where `clk_out` is low. In the cycle sampled just before `ready` rises after a source change, `clk_out` is 0.
- R8: In the cycle after a write that changes the source code, `ready` is 0. `ready` returns to 1 once the change is applied. A write that keeps the source code unchanged leaves `ready` at 1.
- R9: While `en` is low, the phase bit, the half-rate bit, the counter and the toggle stage all hold, so `clk_out` stays constant. When `en` returns high, the output resumes its programmed period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast input clock |
| rst | input | 1 | synchronous active-high reset |
| en | input | 1 | advances the divider stages when high |
| wr_en | input | 1 | host write strobe |
| wr_preset | input | 8 | reload value P for the down-counter |
| wr_sel | input | 2 | source code: 0 full rate, 1 half rate, 2 programmable, 3 low |
| clk_out | output | 1 | registered selected output |
| ready | output | 1 | applied source equals the last written code |

## Verification
A table of vectors steps through all four source codes, and every step changes the code. This shows that each source has its own timing, and that `ready` drops and comes back on each switch. The reload values 0, 3, 5 and 255 separate the 4×(P+1) law from an off-by-one error and confirm the full counter width. A change of reload value while the programmable source is selected shows whether a partial half-period can appear. Holding `en` low, and asserting reset in the middle of a run, separate a frozen or cleared state from a design that keeps running.

// File: rtl/progclk_pkg.sv
package progclk_pkg;

    typedef enum logic [1:0] {
        SRC_FULL = 2'd0,
        SRC_HALF = 2'd1,
        SRC_PROG = 2'd2,
        SRC_OFF  = 2'd3
    } src_sel_e;

    localparam int SRC_COUNT = 4;
    localparam int TICK_SPAN = 4;

    typedef logic [SRC_COUNT-1:0] src_levels_t;

    typedef struct packed {
        logic full_lv;
        logic half_lv;
        logic tick;
    } pre_bus_t;

    typedef struct packed {
        src_sel_e pend;
        src_sel_e cur;
    } sel_state_t;

    function automatic logic pick_level(src_sel_e s, src_levels_t lv);
        return lv[s];
    endfunction

    function automatic int half_len(int preset);
        return TICK_SPAN * (preset + 1);
    endfunction

endpackage

// File: rtl/progclk_prescale.sv
module progclk_prescale
    import progclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    output pre_bus_t pre
);
    logic ph_q;
    logic half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= 1'b0;
            half_q <= 1'b0;
        end else if (en) begin
            ph_q <= ~ph_q;
            if (ph_q) begin
                half_q <= ~half_q;
            end
        end
    end

    always_comb begin
        pre.full_lv = ph_q;
        pre.half_lv = half_q;
        pre.tick    = en & ph_q & ~half_q;
    end

    a_r9_prescale_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(ph_q) && $stable(half_q)));

    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        pre.tick |=> !pre.tick);

endmodule

// File: rtl/progclk_counter.sv
module progclk_counter #(
    parameter int PRESET_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                wr_en,
    input  logic [PRESET_W-1:0] wr_preset,
    output logic                term
);
    localparam logic [PRESET_W-1:0] ZERO = '0;
    localparam logic [PRESET_W-1:0] ONE  = {{(PRESET_W-1){1'b0}}, 1'b1};

    logic [PRESET_W-1:0] shadow_q;
    logic [PRESET_W-1:0] cnt_q;
    logic                at_zero;

    assign at_zero = (cnt_q == ZERO);
    assign term    = tick & at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= ZERO;
        end else if (wr_en) begin
            shadow_q <= wr_preset;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ZERO;
        end else if (tick) begin
            if (at_zero) begin
                cnt_q <= shadow_q;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    a_r5_reload_from_shadow: assert property (@(posedge clk) disable iff (rst)
        term |=> (cnt_q == $past(shadow_q)));

    a_r4_term_single: assert property (@(posedge clk) disable iff (rst)
        term |=> !term);

endmodule

// File: rtl/progclk_toggle.sv
module progclk_toggle (
    input  logic clk,
    input  logic rst,
    input  logic term,
    output logic prog_lv
);
    logic tog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q <= 1'b0;
        end else if (term) begin
            tog_q <= ~tog_q;
        end
    end

    assign prog_lv = tog_q;

    a_r4_toggle_hold: assert property (@(posedge clk) disable iff (rst)
        !term |=> $stable(prog_lv));

endmodule

// File: rtl/progclk_select.sv
module progclk_select
    import progclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  src_levels_t levels,
    output logic        out,
    output logic        ready
);
    sel_state_t st_q;
    sel_state_t st_n;
    logic       out_q;
    logic       ready_q;
    logic       past_ok;

    always_comb begin
        st_n = st_q;
        if (wr_en) begin
            st_n.pend = src_sel_e'(wr_sel);
        end
        if (!out_q && (st_q.cur != st_q.pend)) begin
            st_n.cur = st_q.pend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pend <= SRC_OFF;
            st_q.cur  <= SRC_OFF;
            out_q     <= 1'b0;
            ready_q   <= 1'b0;
            past_ok   <= 1'b0;
        end else begin
            st_q    <= st_n;
            out_q   <= pick_level(st_n.cur, levels);
            ready_q <= (st_n.cur == st_n.pend);
            past_ok <= 1'b1;
        end
    end

    assign out   = out_q;
    assign ready = ready_q;

    a_r7_switch_when_low: assert property (@(posedge clk) disable iff (rst)
        (past_ok && (st_q.cur != $past(st_q.cur))) |-> ($past(out_q) == 1'b0));

    a_r6_off_is_low: assert property (@(posedge clk) disable iff (rst)
        (st_q.cur == SRC_OFF) |-> (out_q == 1'b0));

    a_r8_ready_match: assert property (@(posedge clk) disable iff (rst)
        ready_q |-> (st_q.cur == st_q.pend));

endmodule

// File: rtl/progclk_divider.sv
module progclk_divider
    import progclk_pkg::*;
#(
    parameter int PRESET_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                wr_en,
    input  logic [PRESET_W-1:0] wr_preset,
    input  logic [1:0]          wr_sel,
    output logic                clk_out,
    output logic                ready
);
    pre_bus_t    pre;
    logic        term;
    logic        prog_lv;
    src_levels_t levels;

    progclk_prescale u_pre (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .pre (pre)
    );

    progclk_counter #(.PRESET_W(PRESET_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (pre.tick),
        .wr_en     (wr_en),
        .wr_preset (wr_preset),
        .term      (term)
    );

    progclk_toggle u_tog (
        .clk     (clk),
        .rst     (rst),
        .term    (term),
        .prog_lv (prog_lv)
    );

    always_comb begin
        levels           = '0;
        levels[SRC_FULL] = pre.full_lv;
        levels[SRC_HALF] = pre.half_lv;
        levels[SRC_PROG] = prog_lv;
        levels[SRC_OFF]  = 1'b0;
    end

    progclk_select u_sel (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .levels (levels),
        .out    (clk_out),
        .ready  (ready)
    );

endmodule

// File: tb/sim_progclk_divider.sv
`timescale 1ns/1ps
module sim_progclk_divider;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_preset = 8'd0;
    logic [1:0] wr_sel = 2'd3;
    logic       clk_out;
    logic       ready;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    progclk_divider u0 (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en),
        .wr_preset(wr_preset), .wr_sel(wr_sel),
        .clk_out(clk_out), .ready(ready)
    );

    // columns: source code, reload value, expected half-period in cycles
    localparam int NV = 8;
    localparam int VEC [NV][3] = '{
        '{1, 0, 2}, '{2, 0, 4}, '{0, 0, 1}, '{2, 5, 24},
        '{1, 9, 2}, '{2, 255, 1024}, '{0, 3, 1}, '{2, 3, 16}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_write(input int s, input int p);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(s); wr_preset = 8'(p);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_len(output int n);
        logic lvl;
        lvl = clk_out;
        n = 0;
        while (clk_out == lvl && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_ready(output logic prev_lv);
        int g;
        g = 0;
        prev_lv = clk_out;
        while (!ready && g < 5000) begin
            prev_lv = clk_out;
            @(negedge clk);
            g++;
        end
    endtask

    task automatic measure(input string req, input int exp);
        int a;
        int b;
        run_len(a);
        run_len(a);
        run_len(a);
        run_len(b);
        chk(a == exp, req, a, exp);
        chk(b == exp, req, b, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic pv;
        int   hi;
        int   runs [8];
        int   longs;
        logic cap;
        int   moved;
        int   prev_sel;

        repeat (4) @(negedge clk);
        chk(clk_out == 1'b0, "R1 out in reset", int'(clk_out), 0);
        chk(ready == 1'b0, "R1 ready in reset", int'(ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
        hi = 0;
        for (int i = 0; i < 30; i++) begin
            if (clk_out) hi++;
            @(negedge clk);
        end
        chk(hi == 0, "R1 R6 low after reset", hi, 0);

        prev_sel = 3;
        for (int v = 0; v < NV; v++) begin
            host_write(VEC[v][0], VEC[v][1]);
            if (VEC[v][0] != prev_sel)
                chk(ready == 1'b0, "R8 ready drops on change", int'(ready), 0);
            wait_ready(pv);
            chk(ready == 1'b1, "R8 ready returns", int'(ready), 1);
            chk(pv == 1'b0, "R7 switch while low", int'(pv), 0);
            case (VEC[v][0])
                0: measure("R2 full-rate half-period", VEC[v][2]);
                1: measure("R3 half-rate half-period", VEC[v][2]);
                default: measure("R4 programmable half-period", VEC[v][2]);
            endcase
            prev_sel = VEC[v][0];
        end

        // R5: change reload value 3 -> 1 with programmable source kept
        host_write(2, 1);
        chk(ready == 1'b1, "R8 same code keeps ready", int'(ready), 1);
        run_len(hi);
        longs = 0;
        for (int i = 0; i < 8; i++) begin
            run_len(runs[i]);
            if (runs[i] == 16) longs++;
            chk(runs[i] == 16 || runs[i] == 8, "R5 whole half-periods", runs[i], 8);
        end
        chk(longs <= 1, "R5 at most one old half", longs, 1);
        chk(runs[7] == 8, "R5 new length applied", runs[7], 8);

        // R6: constant low
        host_write(3, 0);
        wait_ready(pv);
        chk(pv == 1'b0, "R7 switch to off while low", int'(pv), 0);
        hi = 0;
        for (int i = 0; i < 50; i++) begin
            if (clk_out) hi++;
            @(negedge clk);
        end
        chk(hi == 0, "R6 output stays low", hi, 0);

        // R9: enable low freezes
        host_write(1, 0);
        wait_ready(pv);
        run_len(hi);
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        cap = clk_out;
        moved = 0;
        for (int i = 0; i < 20; i++) begin
            if (clk_out != cap) moved++;
            @(negedge clk);
        end
        chk(moved == 0, "R9 output frozen", moved, 0);
        en = 1'b1;
        measure("R9 resumes half-rate", 2);

        // R1: reset in the middle of a run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(clk_out == 1'b0, "R1 mid-run reset out", int'(clk_out), 0);
        chk(ready == 1'b0, "R1 mid-run reset ready", int'(ready), 0);
        rst = 1'b0;
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (clk_out) hi++;
        end
        chk(hi == 0, "R1 off source after reset", hi, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule